// File: doc/BRIEF.md
# Packetizing Bulk Byte Framer

This block carries a bulk payload of known total length over a byte stream, cutting it into packets whose maximum length is a power of two chosen at start time, from 256 up to 8192 bytes. Ahead of every packet it emits one marker byte. The marker's low bits say whether this packet is the only one, the opening one of several, or one in the middle. When checksum protection is selected, two CRC bytes follow each packet's payload. Packets are emitted back to back, and the framer never waits for any reply from the far end.

A controller pulses `start` together with the total byte count, a packet size code and the checksum select. The payload then flows in on a valid/ready byte stream and the framed bytes leave on a valid/ready byte stream. Back-pressure rules are as follows. A framer-generated byte (marker or CRC) is offered with `out_valid` high and stays stable until `out_ready` accepts it. During payload, bytes pass straight through: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and a byte moves on any cycle where both valid and ready are high. A request with a zero byte count is refused.

Top module: `pkt_framer`

## Requirements
- R1: After reset, `busy`, `len_err`, `out_valid` and `in_ready` are all low.
- R2: The packet capacity is 2^(8+`size_code`) bytes for codes 0 to 5. Codes 6 and 7 behave as code 5 (8192 bytes).
- R3: Every packet starts with a marker byte 0xF0 OR order. The order is 3 when the bytes still to send fit in one packet. It is 1 for the opening packet of several, and 2 for any packet after the opening one that is not the last.
- R4: Each packet carries the full capacity of payload bytes, or the remaining bytes when fewer are left. Payload bytes are sent in arrival order, and exactly `total_len` payload bytes are consumed.
- R5: With `crc_en` high, each packet's payload is followed by a CRC16 (polynomial 0x1021, MSB-first, seed 0xFFFF restarted for every packet). The CRC covers that packet's payload only and is sent high byte first. With `crc_en` low, no CRC bytes are sent.
- R6: Packets follow each other with no pause other than back-pressure. `busy` is high from the cycle after an accepted start until the final byte has been accepted, and falls right after it.
- R7: A marker or CRC byte offered while `out_ready` is low stays offered with unchanged value. `in_ready` is high only in the payload phase, and only while `out_ready` is high.
- R8: A start with `total_len` of zero sets `len_err` on the next cycle, leaves `busy` low and produces no output. `len_err` is cleared by the next start with a nonzero length.
- R9: `start` is ignored while `busy` is high. The transfer in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (sampled when idle) |
| total_len | input | LEN_W | Payload byte count for the transfer |
| size_code | input | 3 | Packet capacity select, 2^(8+code) bytes |
| crc_en | input | 1 | Append per-packet CRC16 |
| busy | output | 1 | Transfer in progress |
| len_err | output | 1 | Last start had a zero length |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Payload byte taken this cycle if valid |
| in_data | input | 8 | Payload byte |
| out_valid | output | 1 | Framed byte available |
| out_ready | input | 1 | Downstream accepts the framed byte |
| out_data | output | 8 | Framed byte |

## Verification
A wrong remaining count or packet counter shows up at the first marker byte after the fault. The marker's order code, or where it lands in the stream, goes wrong within one packet. A bad CRC seed or update shows up at the first CRC byte of the packet concerned. Stall bugs show up within a single stalled cycle as a marker or CRC byte changing, or as `in_ready` rising while `out_ready` is low. A bad end-of-transfer decision shows up as `busy` staying high, or as extra or missing bytes, on the cycle after the final byte.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned MIN_LOG  = 8;
  localparam int unsigned MAX_LOG  = 13;
  localparam int unsigned MAX_CODE = MAX_LOG - MIN_LOG;
  localparam int unsigned PKT_W    = MAX_LOG + 1;

  localparam logic [3:0]  MARK_HI  = 4'hF;
  localparam logic [1:0]  ORD_OPEN = 2'd1;
  localparam logic [1:0]  ORD_MID  = 2'd2;
  localparam logic [1:0]  ORD_LAST = 2'd3;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MARK,
    ST_PAY,
    ST_CRC_HI,
    ST_CRC_LO
  } st_e;
endpackage

// File: rtl/framer_crc16.sv
module framer_crc16
  import framer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  data,
  output logic [15:0] crc
);
  logic [15:0] chain [9];
  logic [15:0] crc_q;

  assign chain[0] = crc_q;

  // One XOR/shift stage per data bit, MSB first.
  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic fb;
    assign fb = chain[b][15] ^ data[7-b];
    assign chain[b+1] = {chain[b][14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= CRC_SEED;
    else if (clr) crc_q <= CRC_SEED;
    else if (upd) crc_q <= chain[8];
  end

  assign crc = crc_q;
endmodule

// File: rtl/framer_seq.sv
module framer_seq
  import framer_pkg::*;
#(
  parameter int unsigned LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] total_len,
  input  logic [2:0]       size_code,
  input  logic             crc_en,
  input  logic             in_valid,
  input  logic             out_ready,
  output st_e              st,
  output logic [7:0]       mark,
  output logic             beat,
  output logic             crc_clr,
  output logic             busy,
  output logic             len_err
);
  st_e              st_q;
  logic [LEN_W-1:0] rem_q;
  logic [PKT_W-1:0] pcnt_q;
  logic             first_q;
  logic             crc_en_q;
  logic [2:0]       code_q;
  logic             err_q;

  logic [2:0]       eff_code;
  logic [LEN_W-1:0] psize;
  logic             fits;
  logic [1:0]       order;
  logic [PKT_W-1:0] pkt_n;

  assign eff_code = (code_q > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code_q;
  assign psize    = LEN_W'(1) << (MIN_LOG + 32'(eff_code));
  assign fits     = (rem_q <= psize);
  assign order    = fits ? ORD_LAST : (first_q ? ORD_OPEN : ORD_MID);
  assign pkt_n    = fits ? rem_q[PKT_W-1:0] : psize[PKT_W-1:0];

  assign beat     = (st_q == ST_PAY) && in_valid && out_ready;
  assign crc_clr  = (st_q == ST_MARK) && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rem_q    <= '0;
      pcnt_q   <= '0;
      first_q  <= 1'b0;
      crc_en_q <= 1'b0;
      code_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (total_len == '0) begin
              err_q <= 1'b1;
            end else begin
              err_q    <= 1'b0;
              rem_q    <= total_len;
              first_q  <= 1'b1;
              crc_en_q <= crc_en;
              code_q   <= size_code;
              st_q     <= ST_MARK;
            end
          end
        end
        ST_MARK: begin
          if (out_ready) begin
            pcnt_q  <= pkt_n;
            first_q <= 1'b0;
            st_q    <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (beat) begin
            rem_q  <= rem_q - 1'b1;
            pcnt_q <= pcnt_q - 1'b1;
            if (pcnt_q == PKT_W'(1)) begin
              if (crc_en_q)                st_q <= ST_CRC_HI;
              else if (rem_q == LEN_W'(1)) st_q <= ST_IDLE;
              else                         st_q <= ST_MARK;
            end
          end
        end
        ST_CRC_HI: begin
          if (out_ready) st_q <= ST_CRC_LO;
        end
        ST_CRC_LO: begin
          if (out_ready) st_q <= (rem_q == '0) ? ST_IDLE : ST_MARK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st      = st_q;
  assign mark    = {MARK_HI, 2'b00, order};
  assign busy    = (st_q != ST_IDLE);
  assign len_err = err_q;
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import framer_pkg::*;
#(
  parameter int unsigned LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] total_len,
  input  logic [2:0]       size_code,
  input  logic             crc_en,
  output logic             busy,
  output logic             len_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  st_e         st;
  logic [7:0]  mark;
  logic        beat;
  logic        crc_clr;
  logic [15:0] crc;

  framer_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .total_len (total_len),
    .size_code (size_code),
    .crc_en    (crc_en),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .st        (st),
    .mark      (mark),
    .beat      (beat),
    .crc_clr   (crc_clr),
    .busy      (busy),
    .len_err   (len_err)
  );

  framer_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .upd   (beat),
    .data  (in_data),
    .crc   (crc)
  );

  assign in_ready = (st == ST_PAY) && out_ready;

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    case (st)
      ST_MARK:   begin out_valid = 1'b1;     out_data = mark;      end
      ST_PAY:    begin out_valid = in_valid; out_data = in_data;   end
      ST_CRC_HI: begin out_valid = 1'b1;     out_data = crc[15:8]; end
      ST_CRC_LO: begin out_valid = 1'b1;     out_data = crc[7:0];  end
      default:   begin out_valid = 1'b0;     out_data = 8'h00;     end
    endcase
  end
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk
  import framer_pkg::*;
#(
  parameter int unsigned LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] total_len,
  input logic             busy,
  input logic             len_err,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input st_e              st
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready));

  // R3
  mark_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MARK) |-> (out_valid && out_data[7:4] == 4'hF));

  // R7
  hold_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && st != ST_PAY) |=> (out_valid && $stable(out_data)));

  // R7
  in_ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_ready && busy));

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && total_len == '0) |=> (len_err && !busy));
endmodule

bind pkt_framer pkt_framer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .total_len (total_len),
  .busy      (busy),
  .len_err   (len_err),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .st        (st)
);

// File: tb/pkt_framer_tb.sv
module pkt_framer_tb_top;
  localparam int LEN_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] total_len = '0;
  logic [2:0]       size_code = '0;
  logic             crc_en = 1'b0;
  logic             busy, len_err;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_data = 8'h00;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [7:0]       out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pkt_framer #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .size_code(size_code), .crc_en(crc_en), .busy(busy), .len_err(len_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R6 actual=%0d cycles expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int i, input int len);
    return 8'((i * 13 + len * 7 + 5) & 255);
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  // Vector fields: {len[15:0], code[3:0], crc[3:0], mode[3:0], ignore_start[3:0]}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {16'd1,    4'd0, 4'd1, 4'd0, 4'd0},
    {16'd5,    4'd0, 4'd0, 4'd1, 4'd0},
    {16'd256,  4'd0, 4'd1, 4'd1, 4'd0},
    {16'd257,  4'd0, 4'd1, 4'd2, 4'd0},
    {16'd700,  4'd0, 4'd0, 4'd0, 4'd0},
    {16'd600,  4'd1, 4'd1, 4'd2, 4'd0},
    {16'd1025, 4'd2, 4'd1, 4'd1, 4'd0},
    {16'd8194, 4'd7, 4'd0, 4'd0, 4'd0},
    {16'd40,   4'd3, 4'd1, 4'd0, 4'd1}
  };

  task automatic run_vec(input int len, input int code, input bit use_crc,
                         input int mode, input bit ign);
    logic [7:0] exp_q[$];
    bit         ctl_q[$];
    int rem, idx, ps, n, eff, pos, in_idx, bad, ctl_bad, k, ord;
    bit first;
    logic [15:0] c;
    eff = (code > 5) ? 5 : code;
    ps = 1 << (8 + eff);
    rem = len; idx = 0; first = 1;
    while (rem > 0) begin
      n = (rem < ps) ? rem : ps;
      ord = (rem <= ps) ? 3 : (first ? 1 : 2);
      exp_q.push_back(8'(8'hF0 | ord)); ctl_q.push_back(1);
      c = 16'hFFFF;
      for (int j = 0; j < n; j++) begin
        exp_q.push_back(pay(idx, len)); ctl_q.push_back(0);
        c = crc_step(c, pay(idx, len));
        idx++;
      end
      if (use_crc) begin
        exp_q.push_back(c[15:8]); ctl_q.push_back(1);
        exp_q.push_back(c[7:0]);  ctl_q.push_back(1);
      end
      rem -= n; first = 0;
    end

    @(negedge clk);
    start = 1; total_len = LEN_W'(len); size_code = 3'(code); crc_en = use_crc;
    @(negedge clk);
    start = 0;
    pos = 0; in_idx = 0; bad = 0; ctl_bad = 0; k = 0;
    while (pos < exp_q.size() && k < 40000) begin
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (k % 3 != 0) : (k % 4 != 1);
      in_valid  = (mode == 2) ? (k % 5 != 0) : 1'b1;
      in_data   = pay(in_idx, len);
      start     = ign && (k == 30);
      total_len = ign ? LEN_W'(3) : LEN_W'(len);
      #1;
      if (out_valid && out_ready) begin
        if (out_data !== exp_q[pos]) begin
          if (bad == 0)
            $display("FAIL R3/R4/R5 byte %0d actual=%0h expected=%0h", pos, out_data, exp_q[pos]);
          bad++;
        end
        if (ctl_q[pos] && in_ready) ctl_bad++;
        pos++;
      end
      if (!out_ready && in_ready) ctl_bad++;
      if (in_valid && in_ready) in_idx++;
      k++;
      @(negedge clk);
    end
    start = 0; in_valid = 0;
    // R2 R3 R4 R5: whole framed stream matches
    chk(bad == 0, "R2 R3 R4 R5 stream content", bad, 0);
    chk(pos == exp_q.size(), "R6 framed byte count", pos, exp_q.size());
    // R4: exactly len payload bytes consumed
    chk(in_idx == len, "R4 payload consumed", in_idx, len);
    // R7: no payload taken during marker/CRC or while stalled
    chk(ctl_bad == 0, "R7 in_ready gating", ctl_bad, 0);
    // R6 R9: done right after the final byte, nothing more emitted
    chk(!busy && !out_valid, ign ? "R9 ignored start" : "R6 busy release", {busy, out_valid}, 0);
    out_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!busy && !len_err && !out_valid && !in_ready, "R1 reset state",
        {busy, len_err, out_valid, in_ready}, 0);

    // R8: zero length refused
    start = 1; total_len = '0;
    @(negedge clk);
    start = 0;
    chk(len_err && !busy, "R8 zero length flag", {len_err, busy}, 2);
    out_ready = 1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy, "R8 no output", {out_valid, busy}, 0);
    out_ready = 0;

    // R7: stalled marker held stable
    start = 1; total_len = LEN_W'(2); size_code = 0; crc_en = 0;
    @(negedge clk);
    start = 0;
    chk(!len_err, "R8 flag cleared", len_err, 0);
    chk(out_valid && out_data == 8'hF3, "R7 marker offered", out_data, 8'hF3);
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == 8'hF3 && !in_ready, "R7 marker held", out_data, 8'hF3);
    out_ready = 1; in_valid = 1; in_data = 8'hA5;
    @(negedge clk);
    chk(out_valid && in_ready && out_data == 8'hA5, "R7 payload pass", out_data, 8'hA5);
    @(negedge clk);
    in_data = 8'h5A;
    #1;
    chk(out_data == 8'h5A, "R4 second byte", out_data, 8'h5A);
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    chk(!busy, "R6 short done", busy, 0);

    for (int v = 0; v < NV; v++)
      run_vec(int'(VEC[v][31:16]), int'(VEC[v][15:12]), VEC[v][8], int'(VEC[v][7:4]), VEC[v][0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule